// File: doc/BRIEF.md
# I2S Stereo Sample Delay Line

This block delays a stereo serial audio stream by a whole number of frames. It works as a slave on an I2S link. The bit clock and the frame clock come from outside, together with one serial data line. Every 24-bit left and right word it receives is stored in a circular sample store. The word stored some frames earlier is shifted out on a serial data line that uses the same framing. No arithmetic touches the data, so any 24-bit payload comes out bit for bit. Several instances can be chained to reach longer delays.

A two-bit select input picks one of four delay lengths, each a fraction of the store depth. The select may be changed while audio runs. When it changes, the block takes the new length at once and drives the output low until the new delay has elapsed. The frame during which the change happened is thrown away. The same mute sequence runs after reset, so no stale store content ever reaches the output. The bit and frame clocks are oversampled by a faster system clock, which runs every register in the block.

Top module: `i2s_delay_line`

## Requirements
- R1: Input words are read on rising bit-clock edges. A frame-clock level of 0 marks the left channel and 1 marks the right channel. The MSB is in the second bit slot after a frame-clock transition, followed by 23 more bits, MSB first.
- R2: Output words use the same slot positions as the input. The output changes only after a falling bit-clock edge. Slot 0 and slots 25 to 31 of each channel are driven low.
- R3: A frame starts with a falling frame-clock transition. A word pair received in frame f is transmitted in frame f+N+1, where N is the selected sample count.
- R4: The select encoding, with D the store depth parameter, is: 2'b11 gives N=D, 2'b01 gives N=3D/4, 2'b10 gives N=D/2, 2'b00 gives N=D/4.
- R5: Every 24-bit value passes unchanged, including all-ones, all-zeros and 24'h800001. Left words stay on the left and right words stay on the right.
- R6: After reset the output stays low for the first N+1 frames (frames 0 to N). Frame N+1 carries frame 0.
- R7: A select change made in frame k forces the output low before the second rising bit-clock edge that follows it. The output then stays low for the rest of frame k and for frames k+1 to k+N+1, where N is the new count.
- R8: Words received in frame k (the change frame) are never transmitted. Frame k+N+2 carries frame k+1 at the new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Serial bit clock, 64 periods per frame |
| lrclk_i | input | 1 | Frame clock: low for left, high for right |
| sd_i | input | 1 | Serial data input |
| delay_sel_i | input | 2 | Delay length select |
| sd_o | output | 1 | Delayed serial data output |

## Verification
A read pointer that is off by even one slot shifts every word by a whole frame. The scoreboard catches this on the first unmuted frame after reset or after a change. An error in the mute counter shows up at the boundary between silence and audio: that boundary moves by whole frames, and the first audible frame is either zero or a word from the discarded change frame. Bit-counter or shift faults damage the very first non-zero word. Channel mix-ups show up as swapped halves in the compared 48-bit frame value.

// File: rtl/i2sdl_pkg.sv
package i2sdl_pkg;

   typedef enum logic [1:0] {
      SEL_QUARTER = 2'b00,
      SEL_THREEQ  = 2'b01,
      SEL_HALF    = 2'b10,
      SEL_FULL    = 2'b11
   } dl_sel_e;

   // number of frames held back, before the fixed one-frame transfer latency
   function automatic int unsigned sel_to_frames(input logic [1:0] sel, input int unsigned depth);
      case (dl_sel_e'(sel))
         SEL_FULL:   return depth;
         SEL_THREEQ: return (depth / 4) * 3;
         SEL_HALF:   return depth / 2;
         default:    return depth / 4;
      endcase
   endfunction

endpackage

// File: rtl/i2sdl_sync_edge.sv
module i2sdl_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic bclk_i,
   input  logic lrclk_i,
   input  logic sd_i,
   output logic bclk_rise,
   output logic bclk_fall,
   output logic lr_s,
   output logic sd_s
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2sdl_sync_edge: STAGES must be at least 2");
   end

   // bit order {bclk, lrclk, data}; idle state is both clocks high
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] q;
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) q <= 3'b110;
            else     q <= {bclk_i, lrclk_i, sd_i};
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) q <= 3'b110;
            else     q <= g_stage[g-1].q;
         end
      end
   end

   logic bclk_d;
   always_ff @(posedge clk) begin
      if (rst) bclk_d <= 1'b1;
      else     bclk_d <= g_stage[LAST].q[2];
   end

   assign bclk_rise = g_stage[LAST].q[2] & ~bclk_d;
   assign bclk_fall = ~g_stage[LAST].q[2] & bclk_d;
   assign lr_s      = g_stage[LAST].q[1];
   assign sd_s      = g_stage[LAST].q[0];
endmodule

// File: rtl/i2sdl_rx.sv
module i2sdl_rx #(
   parameter int SAMPLE_W  = 24,
   parameter int SLOT_BITS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bclk_rise,
   input  logic                lr,
   input  logic                sd,
   output logic                word_vld,
   output logic                word_chan,
   output logic [SAMPLE_W-1:0] word
);
   localparam int CW = $clog2(SLOT_BITS);

   logic                lr_q;
   logic [CW-1:0]       cnt_q, cnt_n;
   logic [SAMPLE_W-1:0] sh_q, sh_n;
   logic                in_data;

   always_comb begin
      cnt_n = cnt_q;
      if (lr != lr_q)                          cnt_n = '0;
      else if (cnt_q != CW'(SLOT_BITS - 1))    cnt_n = cnt_q + CW'(1);
   end

   assign sh_n    = {sh_q[SAMPLE_W-2:0], sd};
   assign in_data = (cnt_n != '0) && (cnt_n <= CW'(SAMPLE_W));

   always_ff @(posedge clk) begin
      if (rst) begin
         lr_q      <= 1'b1;
         cnt_q     <= CW'(SLOT_BITS - 1);
         sh_q      <= '0;
         word_vld  <= 1'b0;
         word_chan <= 1'b0;
         word      <= '0;
      end else begin
         word_vld <= 1'b0;
         if (bclk_rise) begin
            lr_q  <= lr;
            cnt_q <= cnt_n;
            if (in_data) sh_q <= sh_n;
            if (cnt_n == CW'(SAMPLE_W)) begin
               word_vld  <= 1'b1;
               word_chan <= lr;
               word      <= sh_n;
            end
         end
      end
   end

   // R1: a completed word is a single-cycle event
   assert_word_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      word_vld |=> !word_vld);
endmodule

// File: rtl/i2sdl_ring.sv
module i2sdl_ring #(
   parameter int SAMPLE_W = 24,
   parameter int DEPTH    = 4096,
   parameter int AW       = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_tick,
   input  logic                wr_vld,
   input  logic                wr_chan,
   input  logic [SAMPLE_W-1:0] wr_word,
   input  logic                discard,
   input  logic [AW-1:0]       delay,
   output logic [SAMPLE_W-1:0] rd_left,
   output logic [SAMPLE_W-1:0] rd_right
);
   localparam int SLOTS = DEPTH + 1;
   localparam int PW    = AW + 1;

   logic [2*SAMPLE_W-1:0] store [SLOTS];
   logic [AW-1:0]         fptr_q, fptr_nx, rd_addr;
   logic [PW-1:0]         back, sum_raw, sum_wrap;

   assign fptr_nx = (fptr_q == AW'(SLOTS - 1)) ? '0 : fptr_q + AW'(1);

   // slot read at the start of the next frame lies delay+1 frames behind it
   always_comb begin
      back     = PW'(delay) + PW'(1);
      sum_raw  = {1'b0, fptr_nx} + PW'(SLOTS) - back;
      sum_wrap = (sum_raw >= PW'(SLOTS)) ? sum_raw - PW'(SLOTS) : sum_raw;
      rd_addr  = sum_wrap[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)             fptr_q <= '0;
      else if (frame_tick) fptr_q <= fptr_nx;
   end

   always_ff @(posedge clk) begin
      if (wr_vld && !discard) begin
         if (wr_chan) store[fptr_q][SAMPLE_W-1:0]          <= wr_word;
         else         store[fptr_q][2*SAMPLE_W-1:SAMPLE_W] <= wr_word;
      end
   end

   assign rd_left  = store[rd_addr][2*SAMPLE_W-1:SAMPLE_W];
   assign rd_right = store[rd_addr][SAMPLE_W-1:0];

   // R3: writes come on rising edges, frame starts on falling ones
   assert_no_tick_write_R3: assert property (@(posedge clk) disable iff (rst)
      !(frame_tick && wr_vld));
   // R3: the frame pointer never leaves the ring
   assert_ptr_in_ring_R3: assert property (@(posedge clk) disable iff (rst)
      fptr_q < AW'(SLOTS));
endmodule

// File: rtl/i2sdl_tx.sv
module i2sdl_tx #(
   parameter int SAMPLE_W  = 24,
   parameter int SLOT_BITS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bclk_fall,
   input  logic                lr,
   input  logic                mute,
   input  logic [SAMPLE_W-1:0] left_w,
   input  logic [SAMPLE_W-1:0] right_w,
   output logic                frame_tick,
   output logic                sd_o
);
   localparam int CW = $clog2(SLOT_BITS);

   logic                lr_q;
   logic [CW-1:0]       cnt_q, cnt_n;
   logic [SAMPLE_W-1:0] sh_q, hold_r;
   logic                bit_q;
   logic                in_data;

   assign frame_tick = bclk_fall && lr_q && !lr;

   always_comb begin
      cnt_n = cnt_q;
      if (lr != lr_q)                          cnt_n = '0;
      else if (cnt_q != CW'(SLOT_BITS - 1))    cnt_n = cnt_q + CW'(1);
   end

   assign in_data = (cnt_n != '0) && (cnt_n <= CW'(SAMPLE_W));

   always_ff @(posedge clk) begin
      if (rst) begin
         lr_q   <= 1'b1;
         cnt_q  <= CW'(SLOT_BITS - 1);
         sh_q   <= '0;
         hold_r <= '0;
         bit_q  <= 1'b0;
      end else if (bclk_fall) begin
         lr_q  <= lr;
         cnt_q <= cnt_n;
         if (lr != lr_q) begin
            bit_q <= 1'b0;
            if (!lr) begin
               sh_q   <= left_w;
               hold_r <= right_w;
            end else begin
               sh_q <= hold_r;
            end
         end else if (in_data) begin
            bit_q <= sh_q[SAMPLE_W-1];
            sh_q  <= {sh_q[SAMPLE_W-2:0], 1'b0};
         end else begin
            bit_q <= 1'b0;
         end
      end
   end

   assign sd_o = bit_q & ~mute;

   // R2: the serial bit moves only in the cycle after a falling bit clock
   assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(bclk_fall) |-> $stable(bit_q));
endmodule

// File: rtl/i2sdl_ctrl.sv
module i2sdl_ctrl
   import i2sdl_pkg::*;
#(
   parameter int DEPTH = 4096,
   parameter int AW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    sel_i,
   input  logic          frame_tick,
   output logic [AW-1:0] delay,
   output logic          mute,
   output logic          discard
);
   localparam int MW = $clog2(DEPTH + 3);

   logic [1:0]    sel_m, sel_s, sel_q;
   logic [AW-1:0] delay_new;
   logic [MW-1:0] mute_q;
   logic          chg;

   assign chg       = sel_s != sel_q;
   assign delay_new = AW'(sel_to_frames(sel_s, DEPTH));

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_m   <= SEL_FULL;
         sel_s   <= SEL_FULL;
         sel_q   <= SEL_FULL;
         delay   <= AW'(DEPTH);
         mute_q  <= MW'(DEPTH + 2);
         discard <= 1'b1;
      end else begin
         sel_m <= sel_i;
         sel_s <= sel_m;
         if (chg) begin
            sel_q   <= sel_s;
            delay   <= delay_new;
            // current frame plus N+1 frames of silence
            mute_q  <= MW'(delay_new) + MW'(2);
            discard <= 1'b1;
         end else if (frame_tick) begin
            discard <= 1'b0;
            if (mute_q != '0) mute_q <= mute_q - MW'(1);
         end
      end
   end

   assign mute = mute_q != '0;

   // R4: the delay length moves only on a detected select change
   assert_delay_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !chg |=> $stable(delay));
   // R7: mute window never exceeds the longest delay plus two frames
   assert_mute_bound_R7: assert property (@(posedge clk) disable iff (rst)
      mute_q <= MW'(DEPTH + 2));
   // R8: a dropped frame is always inside a silent window
   assert_discard_muted_R8: assert property (@(posedge clk) disable iff (rst)
      discard |-> mute);
endmodule

// File: rtl/i2s_delay_line.sv
module i2s_delay_line #(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_BITS   = 32,
   parameter int DEPTH       = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bclk_i,
   input  logic       lrclk_i,
   input  logic       sd_i,
   input  logic [1:0] delay_sel_i,
   output logic       sd_o
);
   localparam int AW = $clog2(DEPTH + 1);

   if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
      $error("i2s_delay_line: DEPTH must be a positive multiple of 4");
   end
   if (SAMPLE_W < 2 || SAMPLE_W >= SLOT_BITS) begin : g_bad_width
      $error("i2s_delay_line: SAMPLE_W must fit inside a channel slot");
   end
   if ((1 << $clog2(SLOT_BITS)) != SLOT_BITS) begin : g_bad_slot
      $error("i2s_delay_line: SLOT_BITS must be a power of two");
   end

   logic                bclk_rise, bclk_fall, lr_s, sd_s;
   logic                wr_vld, wr_chan;
   logic [SAMPLE_W-1:0] wr_word, rd_left, rd_right;
   logic                frame_tick, muted, discard;
   logic [AW-1:0]       delay;

   i2sdl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sd_i(sd_i),
      .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .lr_s(lr_s), .sd_s(sd_s));

   i2sdl_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_rx (
      .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .lr(lr_s), .sd(sd_s),
      .word_vld(wr_vld), .word_chan(wr_chan), .word(wr_word));

   i2sdl_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk(clk), .rst(rst), .sel_i(delay_sel_i), .frame_tick(frame_tick),
      .delay(delay), .mute(muted), .discard(discard));

   i2sdl_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_ring (
      .clk(clk), .rst(rst), .frame_tick(frame_tick), .wr_vld(wr_vld),
      .wr_chan(wr_chan), .wr_word(wr_word), .discard(discard), .delay(delay),
      .rd_left(rd_left), .rd_right(rd_right));

   i2sdl_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_tx (
      .clk(clk), .rst(rst), .bclk_fall(bclk_fall), .lr(lr_s), .mute(muted),
      .left_w(rd_left), .right_w(rd_right), .frame_tick(frame_tick), .sd_o(sd_o));

   // R2: the line is low as a new frame begins (last right slot is padding)
   assert_frame_edge_low_R2: assert property (@(posedge clk) disable iff (rst)
      frame_tick |-> !sd_o);
endmodule

// File: tb/i2s_delay_line_bench.sv
`timescale 1ns/1ps
module i2s_delay_line_bench;
   localparam int SW    = 24;
   localparam int DEPTH = 8;
   localparam int HALF  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bclk = 1'b1;
   logic       lrclk = 1'b1;
   logic       sdi = 1'b0;
   logic [1:0] sel = 2'b11;
   logic       sd_o;

   always #2.5 clk = ~clk;

   i2s_delay_line #(.SAMPLE_W(SW), .SLOT_BITS(32), .DEPTH(DEPTH), .SYNC_STAGES(2))
      u_i2s_delay_line (.clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk),
                        .sd_i(sdi), .delay_sel_i(sel), .sd_o(sd_o));

   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [47:0] exp_q[$];
   string       tag_q[$];
   logic [47:0] hist [0:63];
   int          cur_n = DEPTH;
   int          mute_until = DEPTH;
   bit          after_change = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int frames_for(input logic [1:0] s);
      case (s)
         2'b11:   return DEPTH;
         2'b01:   return DEPTH * 3 / 4;
         2'b10:   return DEPTH / 2;
         default: return DEPTH / 4;
      endcase
   endfunction

   task automatic drive_slot(input bit lr, input bit d);
      @(negedge clk);
      bclk = 1'b0; lrclk = lr; sdi = d;
      repeat (HALF) @(negedge clk);
      bclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
   endtask

   // mode 0: none, 1: change at left slot 6, 2: change at right slot 28
   task automatic send_frame(input int g, input logic [23:0] l, input logic [23:0] r,
                             input int mode, input logic [1:0] nsel);
      logic [47:0] e;
      string       tg;
      hist[g] = {l, r};
      if (g <= mute_until) begin
         e  = '0;
         tg = after_change ? "R7 muted after change" : "R6 muted after reset";
      end else begin
         e  = hist[g - cur_n - 1];
         tg = (after_change && g == mute_until + 1) ? "R8 first frame after change"
                                                     : "R1 R3 R4 R5 delayed data";
      end
      if (mode == 1) begin
         e  = {e[47:24] & 24'hF80000, 24'h0};
         tg = "R7 mute inside frame";
      end
      exp_q.push_back(e);
      tag_q.push_back(tg);
      for (int h = 0; h < 2; h++) begin
         for (int s = 0; s < 32; s++) begin
            logic [23:0] w;
            w = (h == 0) ? l : r;
            if ((mode == 1 && h == 0 && s == 6) || (mode == 2 && h == 1 && s == 28)) sel = nsel;
            drive_slot(h[0], (s >= 1 && s <= 24) ? w[24 - s] : 1'b0);
         end
      end
      if (mode != 0) begin
         cur_n        = frames_for(nsel);
         mute_until   = g + cur_n + 1;
         after_change = 1'b1;
      end
   endtask

   // monitor: collects each output frame and pops the scoreboard
   int          m_cnt = 31;
   bit          m_lr = 1'b1;
   bit          m_pad_bad = 1'b0;
   logic [23:0] m_l = '0, m_r = '0;
   always @(posedge bclk) begin
      if (lrclk != m_lr) m_cnt = 0;
      else if (m_cnt != 31) m_cnt++;
      m_lr = lrclk;
      if (m_cnt >= 1 && m_cnt <= 24) begin
         if (!lrclk) m_l = {m_l[22:0], sd_o};
         else        m_r = {m_r[22:0], sd_o};
      end else if (sd_o !== 1'b0) begin
         m_pad_bad = 1'b1;
      end
      if (lrclk && m_cnt == 24) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected frame", {m_l, m_r}, '0);
         end else begin
            logic [47:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({m_l, m_r} === e, t, {m_l, m_r}, e);
         end
         check(!m_pad_bad, "R2 padding slots low", {47'b0, m_pad_bad}, '0);
         m_pad_bad = 1'b0;
      end
   end

   function automatic logic [23:0] pat_l(input int g);
      logic [23:0] v;
      v = 24'(g * 24'h9E3779) ^ 24'h5A5A5A;
      if (g == 10) v = 24'hFFFFFF;
      if (g == 12) v = 24'h000000;
      return v;
   endfunction

   function automatic logic [23:0] pat_r(input int g);
      logic [23:0] v;
      v = ~pat_l(g) ^ {8'(g), 16'h0F0F};
      if (g == 10) v = 24'h800001;
      return v;
   endfunction

   initial begin
      // preamble: one idle right-channel slot while reset is released
      for (int s = 0; s < 32; s++) begin
         if (s == 2) check(sd_o === 1'b0, "R6 low during reset", {47'b0, sd_o}, '0);
         if (s == 4) rst = 1'b0;
         drive_slot(1'b1, 1'b0);
      end
      for (int g = 0; g < 56; g++) begin
         int          mode;
         logic [1:0]  ns;
         mode = 0; ns = sel;
         if (g == 19) begin mode = 2; ns = 2'b10; end
         if (g == 31) begin mode = 1; ns = 2'b00; end
         if (g == 41) begin mode = 2; ns = 2'b01; end
         send_frame(g, pat_l(g), pat_r(g), mode, ns);
      end
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R3 all frames seen", 48'(exp_q.size()), '0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R3 actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule